// File: doc/BRIEF.md
# Range Invalidation Address Calculator

This block turns a 64-bit range-invalidation operand into the address window the invalidation covers. It decodes a translation-granule code, a scale, a count and a signed base from fixed fields of the operand. It then produces a start address and an end address, both 64 bits wide, along with a flag that says whether the operand describes a usable range. The end address is clamped when the range would carry past address bit 52.

A small selector forms the 52-bit address-mode flag. Its inputs are the translation regime, a feature-present input and two control bits, one taken from position 32 and one from position 59 of the regime's translation-control register. The computation runs in a two-stage pipeline. Each side has a valid/ready handshake, and results leave in the order the operands entered.

Top module: `tlbr_range_calc`

## Requirements
- R1: When operand bits [47:46] equal 2'b00, the result reports out_ok=0 and out_start=out_end=0.
- R2: Without 52-bit mode, granule codes 2'b01, 2'b10 and 2'b11 (4KB, 16KB, 64KB) place operand bits [36:0] at address bit 12, 14 and 16. Operand bit 36 fills every address bit above the field, up to bit 63, and the bits below the field are zero.
- R3: In 52-bit mode the base is placed at address bit 16 for every non-zero granule code, with the same sign fill.
- R4: The scale is operand bits [45:44] and the count is bits [43:39]. The length is (count+1) shifted left by 5*scale+1+g, where g is 12, 14 or 16 for the granule. The product is kept to 64 bits, and out_end = out_start + length modulo 2^64.
- R5: When bit 52 of that sum differs from bit 52 of the start, out_end becomes all ones if start bit 52 is 1, and 2^52-1 if it is 0.
- R6: The 52-bit flag is 0 when in_feat52 is 0. Otherwise regime codes 2'b11 and 2'b10 (monitor and hypervisor regimes) use in_ctl_b32, and codes 2'b01 and 2'b00 (hosted and guest regimes) use in_ctl_b59.
- R7: out_gran equals operand bits [47:46] of the same transfer, and out_ok is 1 exactly when it is non-zero.
- R8: While out_ready is held high, a result appears on the output two clock edges after its operand is accepted, and one operand can be accepted every cycle.
- R9: While out_valid is high and out_ready is low, all outputs hold steady. Results leave in acceptance order with none lost or repeated, and in_ready is high whenever out_valid is low.
- R10: During reset out_valid is 0, and after reset in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_operand | input | 64 | Encoded range operand |
| in_regime | input | 2 | Translation regime code |
| in_feat52 | input | 1 | 52-bit address feature present |
| in_ctl_b32 | input | 1 | Control bit 32 for monitor/hypervisor regimes |
| in_ctl_b59 | input | 1 | Control bit 59 for hosted/guest regimes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_ok | output | 1 | Range is usable |
| out_gran | output | 2 | Granule code of the operand |
| out_start | output | 64 | Start address |
| out_end | output | 64 | End address, saturated |

## Verification
Stage one registers the placed base and the length, and stage two registers the sum and the clamp. With out_ready high, each result is therefore due on the second negative clock edge after the edge that accepted its operand. The bench records the cycle of each acceptance. During an opening stretch with out_ready held high, it requires exactly that two-cycle gap. After that, out_ready is throttled and results are matched in acceptance order against values computed arithmetically when the operand was accepted. Inputs change only at the negative edge, and handshakes are sampled one time unit later, well ahead of the next rising edge.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

    typedef enum logic [1:0] {
        GR_NONE = 2'b00,
        GR_4K   = 2'b01,
        GR_16K  = 2'b10,
        GR_64K  = 2'b11
    } gran_e;

    typedef enum logic [1:0] {
        RG_GUEST  = 2'b00,
        RG_HOSTED = 2'b01,
        RG_HYP    = 2'b10,
        RG_MON    = 2'b11
    } regime_e;

    // log2 of the page size selected by a granule code
    function automatic logic [4:0] gran_shift(input logic [1:0] g);
        case (g)
            GR_4K:   gran_shift = 5'd12;
            GR_16K:  gran_shift = 5'd14;
            GR_64K:  gran_shift = 5'd16;
            default: gran_shift = 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/tlbr_wide_sel.sv
module tlbr_wide_sel
    import tlbr_pkg::*;
(
    input  logic [1:0] regime_i,
    input  logic       feat_i,
    input  logic       ctl_b32_i,
    input  logic       ctl_b59_i,
    output logic       wide_o
);
    logic upper_regime;

    always_comb begin
        upper_regime = (regime_i == RG_MON) || (regime_i == RG_HYP);
        if (!feat_i) begin
            wide_o = 1'b0;
        end else if (upper_regime) begin
            wide_o = ctl_b32_i;
        end else begin
            wide_o = ctl_b59_i;
        end
    end
endmodule

// File: rtl/tlbr_front.sv
module tlbr_front
    import tlbr_pkg::*;
#(
    parameter int OP_W     = 64,
    parameter int ADDR_W   = 64,
    parameter int BASE_W   = 37,
    parameter int CNT_W    = 5,
    parameter int SCL_W    = 2,
    parameter int GR_LSB   = 46,
    parameter int SCL_LSB  = 44,
    parameter int CNT_LSB  = 39,
    parameter int WIDE_POS = 16
) (
    input  logic [OP_W-1:0]   operand_i,
    input  logic              wide_i,
    output logic              ok_o,
    output logic [1:0]        gran_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] len_o
);
    localparam int EXT_W = ADDR_W - BASE_W;
    localparam int PAD_W = ADDR_W - CNT_W;
    localparam int SH_W  = 7;

    logic [1:0]        gran;
    logic [SCL_W-1:0]  scl;
    logic [CNT_W-1:0]  cnt;
    logic [BASE_W-1:0] base;
    logic [ADDR_W-1:0] base_ext;
    logic [4:0]        gsh;
    logic [4:0]        place_sh;
    logic [SH_W-1:0]   len_sh;
    logic [ADDR_W-1:0] cnt_p1;
    logic              unused_bits;

    assign gran = operand_i[GR_LSB +: 2];
    assign scl  = operand_i[SCL_LSB +: SCL_W];
    assign cnt  = operand_i[CNT_LSB +: CNT_W];
    assign base = operand_i[BASE_W-1:0];

    // operand bits outside the decoded fields
    assign unused_bits = ^{operand_i[OP_W-1:GR_LSB+2], operand_i[CNT_LSB-1:BASE_W]};

    // sign fill of the base from its top bit
    generate
        if (EXT_W > 0) begin : g_ext
            assign base_ext = {{EXT_W{base[BASE_W-1]}}, base};
        end else begin : g_noext
            assign base_ext = base[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        gsh      = gran_shift(gran);
        ok_o     = (gran != GR_NONE);
        gran_o   = gran;
        place_sh = (wide_i || gran == GR_64K) ? 5'(WIDE_POS) : gsh;
        len_sh   = SH_W'(scl) * SH_W'(5) + SH_W'(1) + SH_W'(gsh);
        cnt_p1   = {{PAD_W{1'b0}}, cnt} + ADDR_W'(1);
        if (ok_o) begin
            start_o = base_ext << place_sh;
            len_o   = cnt_p1 << len_sh;
        end else begin
            start_o = '0;
            len_o   = '0;
        end
    end
endmodule

// File: rtl/tlbr_back.sv
module tlbr_back #(
    parameter int ADDR_W  = 64,
    parameter int SAT_BIT = 52
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic [ADDR_W-1:0] end_o
);
    logic [ADDR_W-1:0] sum;
    logic              crossed;

    assign sum     = start_i + len_i;
    assign crossed = sum[SAT_BIT] ^ start_i[SAT_BIT];

    // clamp: sign of start above the boundary, ones below it
    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            if (i >= SAT_BIT) begin : g_hi
                assign end_o[i] = crossed ? start_i[SAT_BIT] : sum[i];
            end else begin : g_lo
                assign end_o[i] = crossed ? 1'b1 : sum[i];
            end
        end
    endgenerate
endmodule

// File: rtl/tlbr_range_calc.sv
module tlbr_range_calc
    import tlbr_pkg::*;
#(
    parameter int OP_W     = 64,
    parameter int ADDR_W   = 64,
    parameter int BASE_W   = 37,
    parameter int CNT_W    = 5,
    parameter int SCL_W    = 2,
    parameter int GR_LSB   = 46,
    parameter int SCL_LSB  = 44,
    parameter int CNT_LSB  = 39,
    parameter int WIDE_POS = 16,
    parameter int SAT_BIT  = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_operand,
    input  logic [1:0]        in_regime,
    input  logic              in_feat52,
    input  logic              in_ctl_b32,
    input  logic              in_ctl_b59,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_ok,
    output logic [1:0]        out_gran,
    output logic [ADDR_W-1:0] out_start,
    output logic [ADDR_W-1:0] out_end
);
    typedef struct packed {
        logic              v;
        logic              ok;
        logic [1:0]        gran;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
    } st1_t;

    typedef struct packed {
        logic              v;
        logic              ok;
        logic [1:0]        gran;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] fin;
    } st2_t;

    typedef struct packed {
        st1_t a;
        st2_t b;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic              wide;
    logic              f_ok;
    logic [1:0]        f_gran;
    logic [ADDR_W-1:0] f_start;
    logic [ADDR_W-1:0] f_len;
    logic [ADDR_W-1:0] b_end;
    logic              take_b;

    tlbr_wide_sel u_wide (
        .regime_i  (in_regime),
        .feat_i    (in_feat52),
        .ctl_b32_i (in_ctl_b32),
        .ctl_b59_i (in_ctl_b59),
        .wide_o    (wide)
    );

    tlbr_front #(
        .OP_W     (OP_W),
        .ADDR_W   (ADDR_W),
        .BASE_W   (BASE_W),
        .CNT_W    (CNT_W),
        .SCL_W    (SCL_W),
        .GR_LSB   (GR_LSB),
        .SCL_LSB  (SCL_LSB),
        .CNT_LSB  (CNT_LSB),
        .WIDE_POS (WIDE_POS)
    ) u_front (
        .operand_i (in_operand),
        .wide_i    (wide),
        .ok_o      (f_ok),
        .gran_o    (f_gran),
        .start_o   (f_start),
        .len_o     (f_len)
    );

    tlbr_back #(
        .ADDR_W  (ADDR_W),
        .SAT_BIT (SAT_BIT)
    ) u_back (
        .start_i (pipe_q.a.start),
        .len_i   (pipe_q.a.len),
        .end_o   (b_end)
    );

    always_comb begin
        pipe_d   = pipe_q;
        take_b   = !pipe_q.b.v || out_ready;
        in_ready = !pipe_q.a.v || take_b;

        if (take_b) begin
            pipe_d.b.v = pipe_q.a.v;
            if (pipe_q.a.v) begin
                pipe_d.b.ok    = pipe_q.a.ok;
                pipe_d.b.gran  = pipe_q.a.gran;
                pipe_d.b.start = pipe_q.a.start;
                pipe_d.b.fin   = b_end;
            end
        end

        if (in_ready) begin
            pipe_d.a.v = in_valid;
            if (in_valid) begin
                pipe_d.a.ok    = f_ok;
                pipe_d.a.gran  = f_gran;
                pipe_d.a.start = f_start;
                pipe_d.a.len   = f_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.b.v;
    assign out_ok    = pipe_q.b.ok;
    assign out_gran  = pipe_q.b.gran;
    assign out_start = pipe_q.b.start;
    assign out_end   = pipe_q.b.fin;
endmodule

// File: rtl/tlbr_range_chk.sv
module tlbr_range_chk #(
    parameter int ADDR_W  = 64,
    parameter int SAT_BIT = 52
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_ok,
    input logic [1:0]        out_gran,
    input logic [ADDR_W-1:0] out_start,
    input logic [ADDR_W-1:0] out_end
);
    // R1
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ok) |-> (out_start == '0 && out_end == '0));

    // R7
    gran_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ok == (out_gran != 2'b00)));

    // R5
    end_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ok) |-> (out_end[SAT_BIT] == out_start[SAT_BIT]));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_start)
            && $stable(out_end) && $stable(out_gran) && $stable(out_ok)));

    // R9
    idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    logic unused_in;
    assign unused_in = in_valid;
endmodule

bind tlbr_range_calc tlbr_range_chk #(
    .ADDR_W  (ADDR_W),
    .SAT_BIT (SAT_BIT)
) u_range_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ok    (out_ok),
    .out_gran  (out_gran),
    .out_start (out_start),
    .out_end   (out_end)
);

// File: tb/test_tlbr_range_calc.sv
module test_tlbr_range_calc;
    localparam int N_SWEEP = 768;
    localparam int N_SEL   = 32;
    localparam int N       = N_SWEEP + N_SEL;
    localparam int WD      = 20000;
    localparam int FAST    = 60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_operand;
    logic [1:0]  in_regime;
    logic        in_feat52;
    logic        in_ctl_b32;
    logic        in_ctl_b59;
    logic        out_valid;
    logic        out_ready;
    logic        out_ok;
    logic [1:0]  out_gran;
    logic [63:0] out_start;
    logic [63:0] out_end;

    always #2 clk = ~clk;

    tlbr_range_calc i_tlbr_range_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_operand (in_operand),
        .in_regime  (in_regime),
        .in_feat52  (in_feat52),
        .in_ctl_b32 (in_ctl_b32),
        .in_ctl_b59 (in_ctl_b59),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_ok     (out_ok),
        .out_gran   (out_gran),
        .out_start  (out_start),
        .out_end    (out_end)
    );

    int total = 0;
    int bad   = 0;

    logic [63:0] e_start [N];
    logic [63:0] e_end   [N];
    logic [1:0]  e_gran  [N];
    logic        e_ok    [N];
    logic        e_sat   [N];
    logic        e_wide  [N];
    int          acc_cyc [N];

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic stim(input int idx, output logic [63:0] op, output logic [1:0] rg,
                        output logic ft, output logic c32, output logic c59);
        logic [36:0] bases [6];
        logic [36:0] bs;
        int          nums [4];
        int          b, nm, sc, tg, lg, j;
        bases[0] = 37'h0;          bases[1] = 37'h1;
        bases[2] = 37'h0FFFFFFFFF; bases[3] = 37'h1000000000;
        bases[4] = 37'h1FFFFFFFFF; bases[5] = 37'h0123456789;
        nums[0] = 0; nums[1] = 1; nums[2] = 15; nums[3] = 31;
        op = '0;
        if (idx < N_SWEEP) begin
            b  = idx % 6;
            nm = (idx / 6) % 4;
            sc = (idx / 24) % 4;
            tg = (idx / 96) % 4;
            lg = (idx / 384) % 2;
            bs = bases[b];
            op[63:48] = 16'hA5C3;
            op[47:46] = 2'(tg);
            op[45:44] = 2'(sc);
            op[43:39] = 5'(nums[nm]);
            op[38:37] = 2'b11;
            op[36:0]  = bs;
            rg  = 2'b11;
            ft  = (lg != 0);
            c32 = 1'b1;
            c59 = 1'b0;
        end else begin
            j   = idx - N_SWEEP;
            rg  = 2'(j % 4);
            ft  = ((j / 4) % 2) != 0;
            c32 = ((j / 8) % 2) != 0;
            c59 = ((j / 16) % 2) != 0;
            op[47:46] = 2'b01;
            op[36:0]  = 37'h1;
        end
    endtask

    // independent arithmetic model of the requirements
    task automatic model(input int idx, input logic [63:0] op, input logic [1:0] rg,
                         input logic ft, input logic c32, input logic c59);
        logic        wide;
        int          tg, pos, gsh, sc, cnt;
        longint      sv, strt, len, fin;
        logic [63:0] s_u, f_u;
        wide = ft && (rg[1] ? c32 : c59);
        tg   = int'(op[47:46]);
        sc   = int'(op[45:44]);
        cnt  = int'(op[43:39]);
        e_gran[idx] = op[47:46];
        e_wide[idx] = wide;
        e_sat[idx]  = 1'b0;
        if (tg == 0) begin
            e_ok[idx]    = 1'b0;
            e_start[idx] = '0;
            e_end[idx]   = '0;
        end else begin
            gsh = 10 + 2 * tg;
            pos = (wide || tg == 3) ? 16 : gsh;
            sv  = longint'(op[36:0]);
            if (op[36]) sv = sv - (longint'(1) <<< 37);
            strt = sv * (longint'(1) <<< pos);
            len  = longint'(cnt + 1) * (longint'(1) <<< (5 * sc + 1 + gsh));
            fin  = strt + len;
            s_u  = 64'(strt);
            f_u  = 64'(fin);
            if (f_u[52] != s_u[52]) begin
                e_sat[idx] = 1'b1;
                f_u = s_u[52] ? {64{1'b1}} : ((64'd1 << 52) - 64'd1);
            end
            e_ok[idx]    = 1'b1;
            e_start[idx] = s_u;
            e_end[idx]   = f_u;
        end
    endtask

    initial begin
        int          cyc, wr, rd;
        logic        acc_pend;
        logic [63:0] op;
        logic [1:0]  rg;
        logic        ft, c32, c59;
        string       st_tag, en_tag;

        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_operand = '0;
        in_regime  = '0;
        in_feat52  = 1'b0;
        in_ctl_b32 = 1'b0;
        in_ctl_b59 = 1'b0;
        out_ready  = 1'b1;
        repeat (3) @(negedge clk);
        check64("R10 out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R10 in_ready after reset", 64'(in_ready), 64'd1);
        check64("R10 out_valid after reset", 64'(out_valid), 64'd0);

        cyc = 0; wr = 0; rd = 0; acc_pend = 1'b0;
        while (rd < N && cyc < WD) begin
            @(negedge clk);
            cyc++;
            if (acc_pend) wr++;
            out_ready = (cyc < FAST) ? 1'b1 : (((cyc * 5) % 11) < 7);
            if (wr < N && (cyc % 13) != 5) begin
                stim(wr, op, rg, ft, c32, c59);
                in_operand = op; in_regime = rg; in_feat52 = ft;
                in_ctl_b32 = c32; in_ctl_b59 = c59;
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            acc_pend = in_valid && in_ready;
            if (acc_pend) begin
                model(wr, in_operand, in_regime, in_feat52, in_ctl_b32, in_ctl_b59);
                acc_cyc[wr] = cyc;
            end
            if (out_valid && out_ready) begin
                if (rd >= N_SWEEP)           st_tag = "R6 start";
                else if (!e_ok[rd])          st_tag = "R1 start";
                else if (e_wide[rd])         st_tag = "R3 start";
                else                         st_tag = "R2 start";
                if (!e_ok[rd])               en_tag = "R1 end";
                else if (e_sat[rd])          en_tag = "R5 end";
                else                         en_tag = "R4 end";
                check64(st_tag, out_start, e_start[rd]);
                check64(en_tag, out_end, e_end[rd]);
                check64("R7 gran", 64'(out_gran), 64'(e_gran[rd]));
                check64("R7 ok", 64'(out_ok), 64'(e_ok[rd]));
                if (cyc < FAST)
                    check64("R8 latency", 64'(cyc - acc_cyc[rd]), 64'd2);
                rd++;
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        if (rd < N) begin
            total++; bad++;
            $display("FAIL R9 watchdog act=%0d exp=%0d results", rd, N);
        end
        repeat (4) @(negedge clk);
        // R9: nothing extra after the last result
        check64("R9 no extra result", 64'(out_valid), 64'd0);
        check64("R9 result count", 64'(rd), 64'(N));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule